// File: doc/BRIEF.md
# Two-Level Maskable Interrupt Aggregator

This block collects eight single-bit event inputs into two sticky status registers and raises interrupt lines from them. Three events belong to a real-time-clock group (alarm, one-second tick, periodic) and five to an auxiliary-converter group (four digital comparators and data ready). Each status bit is set by a rising edge of its event input and stays set until a host reads the status register that holds it. The read returns the captured bits and clears them in the same access.

Each group has a mask register next to its status register. The unmasked status bits of a group are ORed into that group's first-level interrupt line. A top-level interrupt output is the OR of the two group lines. The host reaches the four registers through a single-cycle bus with read and write strobes. Read data is combinational in the strobe cycle. A clear or a mask load takes effect at the clock edge that closes the access.

The address decoder has five named selections: SEL_NONE, SEL_RTC_STAT, SEL_AUX_STAT, SEL_RTC_MASK and SEL_AUX_MASK. There are no transitions between them. The selection follows the address in the same cycle, and an unmapped address selects SEL_NONE.

Top module: `irq_rollup_top`

## Requirements
- R1: The real-time-clock status register is read at address 0x19. Bit 7 holds the periodic event (`rtc_evt[2]`), bit 6 holds the one-second tick (`rtc_evt[1]`) and bit 5 holds the alarm (`rtc_evt[0]`).
- R2: The auxiliary status register is read at address 0x1A. Bit 8 holds data ready (`aux_evt[4]`), and bits 7, 6, 5 and 4 hold comparators 4, 3, 2 and 1 (`aux_evt[3:0]`).
- R3: A status bit is set by a low-to-high transition of its event input. After a clear, an input that is held high does not set the bit again.
- R4: A set status bit stays set until its register is read. The read returns the bit and clears it at the closing clock edge.
- R5: If a rising edge arrives in the cycle that reads its status register, the bit is set after the read and is not lost.
- R6: The mask registers sit at 0x21 (real-time clock) and 0x22 (auxiliary), with the same bit positions as their status registers. They reset to 0, they load from a write and they hold otherwise.
- R7: A group interrupt (`irq_rtc`, `irq_aux`) is the OR of that group's status bits whose mask bit is 0. A mask bit of 1 hides its status bit from the interrupt.
- R8: `irq_any` is the OR of `irq_rtc` and `irq_aux`.
- R9: Unused bit positions read as 0 and ignore writes. A write to a status register changes nothing, and a read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register address |
| bus_rd | input | 1 | Read strobe (one cycle) |
| bus_wr | input | 1 | Write strobe (one cycle) |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, valid while bus_rd is high, 0 otherwise |
| rtc_evt | input | 3 | Events: [0] alarm, [1] one-second tick, [2] periodic |
| aux_evt | input | 5 | Events: [3:0] comparators 1..4, [4] data ready |
| irq_rtc | output | 1 | Real-time-clock group interrupt |
| irq_aux | output | 1 | Auxiliary group interrupt |
| irq_any | output | 1 | Top-level interrupt |

## Verification
Two functions can act on a status register in the same cycle: the clear caused by a read, and the set caused by a new rising edge. The bench provokes this collision directly by raising an event in the very cycle that reads its register. Random traffic also produces many collisions, because event toggles and status reads both happen often. The expected result is judged by a bench model in which the set overrides the clear: the bit must show up on the following read, while bits without a new edge must read back as 0.

// File: rtl/irq_rollup_pkg.sv
package irq_rollup_pkg;
    localparam int BUS_AW = 8;
    localparam int BUS_DW = 16;

    localparam int RTC_N   = 3;
    localparam int RTC_LSB = 5;
    localparam int AUX_N   = 5;
    localparam int AUX_LSB = 4;

    localparam logic [BUS_AW-1:0] RTC_STAT_ADDR = 8'h19;
    localparam logic [BUS_AW-1:0] AUX_STAT_ADDR = 8'h1A;
    localparam logic [BUS_AW-1:0] RTC_MASK_ADDR = 8'h21;
    localparam logic [BUS_AW-1:0] AUX_MASK_ADDR = 8'h22;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_RTC_STAT,
        SEL_AUX_STAT,
        SEL_RTC_MASK,
        SEL_AUX_MASK
    } reg_sel_e;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] evt_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= evt_i;
    end

    always_comb rise_o = evt_i & ~prev_q;

    // R3: a held input yields a one-cycle pulse, never two in a row
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o != '0) |=> ((rise_o & $past(rise_o)) == '0));
endmodule

// File: rtl/irq_group.sv
module irq_group #(
    parameter int W   = 3,
    parameter int LSB = 5,
    parameter int DW  = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [W-1:0]  rise_i,
    input  logic          rd_stat_i,
    input  logic          wr_mask_i,
    input  logic [W-1:0]  mask_wdata_i,
    output logic [DW-1:0] stat_word_o,
    output logic [DW-1:0] mask_word_o,
    output logic          irq_o
);
    logic [W-1:0] status_q;
    logic [W-1:0] mask_q;
    logic [W-1:0] pend;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         status_q <= '0;
        else if (rd_stat_i) status_q <= rise_i;
        else                status_q <= status_q | rise_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         mask_q <= '0;
        else if (wr_mask_i) mask_q <= mask_wdata_i;
    end

    always_comb begin
        pend                     = status_q & ~mask_q;
        irq_o                    = |pend;
        stat_word_o              = '0;
        stat_word_o[LSB +: W]    = status_q;
        mask_word_o              = '0;
        mask_word_o[LSB +: W]    = mask_q;
    end

    assert_edge_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_i != '0) |=> ((status_q & $past(rise_i)) == $past(rise_i)));
    assert_read_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        rd_stat_i |=> ((status_q & ~$past(rise_i)) == '0));
    assert_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stat_i |=> ((status_q & $past(status_q)) == $past(status_q)));
    assert_collision_kept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat_i && rise_i != '0) |=> (status_q == $past(rise_i)));
    assert_mask_load_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_mask_i |=> (mask_q == $past(mask_wdata_i)));
    assert_mask_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_mask_i |=> $stable(mask_q));
    assert_unmasked_irq_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q != '0 && mask_q == '0) |-> irq_o);
    assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '1) |-> !irq_o);
endmodule

// File: rtl/irq_rollup_top.sv
module irq_rollup_top
    import irq_rollup_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [BUS_DW-1:0] bus_wdata,
    output logic [BUS_DW-1:0] bus_rdata,
    input  logic [RTC_N-1:0]  rtc_evt,
    input  logic [AUX_N-1:0]  aux_evt,
    output logic              irq_rtc,
    output logic              irq_aux,
    output logic              irq_any
);
    reg_sel_e          sel;
    logic [RTC_N-1:0]  rtc_rise;
    logic [AUX_N-1:0]  aux_rise;
    logic [BUS_DW-1:0] rtc_stat_w, rtc_mask_w, aux_stat_w, aux_mask_w;
    logic              unused_wdata;

    assign unused_wdata = ^bus_wdata;

    always_comb begin
        unique case (bus_addr)
            RTC_STAT_ADDR: sel = SEL_RTC_STAT;
            AUX_STAT_ADDR: sel = SEL_AUX_STAT;
            RTC_MASK_ADDR: sel = SEL_RTC_MASK;
            AUX_MASK_ADDR: sel = SEL_AUX_MASK;
            default:       sel = SEL_NONE;
        endcase
    end

    irq_edge_detect #(.W(RTC_N)) u_rtc_edge (
        .clk(clk), .rst_n(rst_n), .evt_i(rtc_evt), .rise_o(rtc_rise));
    irq_edge_detect #(.W(AUX_N)) u_aux_edge (
        .clk(clk), .rst_n(rst_n), .evt_i(aux_evt), .rise_o(aux_rise));

    irq_group #(.W(RTC_N), .LSB(RTC_LSB), .DW(BUS_DW)) u_rtc_grp (
        .clk(clk), .rst_n(rst_n), .rise_i(rtc_rise),
        .rd_stat_i(bus_rd && sel == SEL_RTC_STAT),
        .wr_mask_i(bus_wr && sel == SEL_RTC_MASK),
        .mask_wdata_i(bus_wdata[RTC_LSB +: RTC_N]),
        .stat_word_o(rtc_stat_w), .mask_word_o(rtc_mask_w), .irq_o(irq_rtc));

    irq_group #(.W(AUX_N), .LSB(AUX_LSB), .DW(BUS_DW)) u_aux_grp (
        .clk(clk), .rst_n(rst_n), .rise_i(aux_rise),
        .rd_stat_i(bus_rd && sel == SEL_AUX_STAT),
        .wr_mask_i(bus_wr && sel == SEL_AUX_MASK),
        .mask_wdata_i(bus_wdata[AUX_LSB +: AUX_N]),
        .stat_word_o(aux_stat_w), .mask_word_o(aux_mask_w), .irq_o(irq_aux));

    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (sel)
                SEL_RTC_STAT: bus_rdata = rtc_stat_w;
                SEL_AUX_STAT: bus_rdata = aux_stat_w;
                SEL_RTC_MASK: bus_rdata = rtc_mask_w;
                SEL_AUX_MASK: bus_rdata = aux_mask_w;
                default:      bus_rdata = '0;
            endcase
        end
        irq_any = irq_rtc | irq_aux;
    end

    assert_idle_read_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rd && sel == SEL_NONE) |-> (bus_rdata == '0));
    assert_top_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_rtc || irq_aux) |-> irq_any);
endmodule

// File: tb/test_irq_rollup_top.sv
module test_irq_rollup_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [2:0]  rtc_evt = '0;
    logic [4:0]  aux_evt = '0;
    logic        irq_rtc, irq_aux, irq_any;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // bench model
    logic [2:0] m_rs = '0, m_rm = '0, m_rp = '0;
    logic [4:0] m_as = '0, m_am = '0, m_ap = '0;
    logic [15:0] last_rd;

    always #4 clk = ~clk;

    irq_rollup_top i_irq_rollup_top (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
        .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rtc_evt(rtc_evt), .aux_evt(aux_evt),
        .irq_rtc(irq_rtc), .irq_aux(irq_aux), .irq_any(irq_any));

    function automatic logic [15:0] exp_rdata(input logic [7:0] a);
        case (a)
            8'h19:   return {8'h00, m_rs, 5'b0};
            8'h1A:   return {7'h00, m_as, 4'b0};
            8'h21:   return {8'h00, m_rm, 5'b0};
            8'h22:   return {7'h00, m_am, 4'b0};
            default: return 16'h0000;
        endcase
    endfunction

    function automatic string addr_tag(input logic [7:0] a);
        case (a)
            8'h19:   return "R1";
            8'h1A:   return "R2";
            8'h21, 8'h22: return "R6";
            default: return "R9";
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic cyc(input logic [2:0] r, input logic [4:0] a, input bit rd, input bit wr,
                       input logic [7:0] ad, input logic [15:0] wd);
        logic ei_r, ei_a;
        @(negedge clk);
        rtc_evt = r; aux_evt = a; bus_rd = rd; bus_wr = wr; bus_addr = ad; bus_wdata = wd;
        #1;
        ei_r = |(m_rs & ~m_rm);
        ei_a = |(m_as & ~m_am);
        check(irq_rtc == ei_r, "R7", 16'(irq_rtc), 16'(ei_r));
        check(irq_aux == ei_a, "R7", 16'(irq_aux), 16'(ei_a));
        check(irq_any == (ei_r | ei_a), "R8", 16'(irq_any), 16'(ei_r | ei_a));
        if (rd) begin
            last_rd = bus_rdata;
            check(bus_rdata == exp_rdata(ad), addr_tag(ad), bus_rdata, exp_rdata(ad));
        end
        @(posedge clk);
        // model update: set wins over the read clear
        if (rd && ad == 8'h19) m_rs = '0;
        if (rd && ad == 8'h1A) m_as = '0;
        m_rs = m_rs | (r & ~m_rp);
        m_as = m_as | (a & ~m_ap);
        m_rp = r; m_ap = a;
        if (wr && ad == 8'h21) m_rm = wd[7:5];
        if (wr && ad == 8'h22) m_am = wd[8:4];
    endtask

    task automatic idle();
        cyc(rtc_evt, aux_evt, 1'b0, 1'b0, 8'h00, 16'h0);
    endtask

    task automatic rd_reg(input logic [7:0] ad);
        cyc(rtc_evt, aux_evt, 1'b1, 1'b0, ad, 16'h0);
    endtask

    task automatic wr_reg(input logic [7:0] ad, input logic [15:0] wd);
        cyc(rtc_evt, aux_evt, 1'b0, 1'b1, ad, wd);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [2:0] r;
        logic [4:0] a;
        void'($urandom(32'h1234ABCD));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state: masks zero (R6), no interrupts
        rd_reg(8'h21); check(last_rd == 16'h0, "R6", last_rd, 16'h0);
        rd_reg(8'h22); check(last_rd == 16'h0, "R6", last_rd, 16'h0);
        rd_reg(8'h19); check(last_rd == 16'h0, "R4", last_rd, 16'h0);

        // alarm edge -> bit 5 of 0x19 (R1), level held does not re-set (R3)
        cyc(3'b001, 5'b0, 1'b0, 1'b0, 8'h00, 16'h0);
        idle();
        check(irq_rtc == 1'b1, "R7", 16'(irq_rtc), 16'h1);
        rd_reg(8'h19); check(last_rd == 16'h0020, "R1", last_rd, 16'h0020);
        idle();
        rd_reg(8'h19); check(last_rd == 16'h0000, "R3", last_rd, 16'h0000);

        // sticky until read (R4)
        cyc(3'b001, 5'b11111, 1'b0, 1'b0, 8'h00, 16'h0);
        repeat (4) idle();
        rd_reg(8'h1A); check(last_rd == 16'h01F0, "R2", last_rd, 16'h01F0);
        rd_reg(8'h1A); check(last_rd == 16'h0000, "R4", last_rd, 16'h0000);

        // individual aux positions: data ready on bit 8, comparator 1 on bit 4
        cyc(3'b001, 5'b00000, 1'b0, 1'b0, 8'h00, 16'h0);
        cyc(3'b001, 5'b10001, 1'b0, 1'b0, 8'h00, 16'h0);
        rd_reg(8'h1A); check(last_rd == 16'h0110, "R2", last_rd, 16'h0110);

        // mask all RTC bits, unused positions ignored (R9, R6)
        wr_reg(8'h21, 16'hFFFF);
        rd_reg(8'h21); check(last_rd == 16'h00E0, "R9", last_rd, 16'h00E0);
        cyc(3'b101, aux_evt, 1'b0, 1'b0, 8'h00, 16'h0);
        idle();
        check(irq_rtc == 1'b0, "R7", 16'(irq_rtc), 16'h0);
        rd_reg(8'h19); check(last_rd == 16'h0080, "R1", last_rd, 16'h0080);
        wr_reg(8'h21, 16'h0000);

        // edge in the same cycle as the read (R5)
        cyc(3'b000, aux_evt, 1'b0, 1'b0, 8'h00, 16'h0);
        cyc(3'b000, aux_evt, 1'b1, 1'b0, 8'h19, 16'h0);
        cyc(3'b010, aux_evt, 1'b1, 1'b0, 8'h19, 16'h0);
        rd_reg(8'h19); check(last_rd == 16'h0040, "R5", last_rd, 16'h0040);

        // status write has no effect, unmapped read is zero (R9)
        cyc(3'b011, aux_evt, 1'b0, 1'b0, 8'h00, 16'h0);
        wr_reg(8'h19, 16'h0000);
        rd_reg(8'h19); check(last_rd == 16'h0020, "R9", last_rd, 16'h0020);
        wr_reg(8'h1A, 16'hFFFF);
        rd_reg(8'h1A); check(last_rd == 16'h0000, "R9", last_rd, 16'h0000);
        rd_reg(8'h20); check(last_rd == 16'h0000, "R9", last_rd, 16'h0000);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            int op;
            r = rtc_evt ^ 3'($urandom & $urandom & $urandom);
            a = aux_evt ^ 5'($urandom & $urandom & $urandom);
            op = int'($urandom % 8);
            case (op)
                0, 1: cyc(r, a, 1'b1, 1'b0, 8'h19, 16'h0);
                2, 3: cyc(r, a, 1'b1, 1'b0, 8'h1A, 16'h0);
                4: cyc(r, a, 1'b1, 1'b0, ($urandom % 2) ? 8'h21 : 8'h22, 16'h0);
                5: cyc(r, a, 1'b0, 1'b1, ($urandom % 2) ? 8'h21 : 8'h22,
                       16'($urandom & $urandom));
                6: cyc(r, a, ($urandom % 2) == 1, ($urandom % 2) == 0,
                       8'($urandom), 16'($urandom));
                default: cyc(r, a, 1'b0, 1'b0, 8'h00, 16'h0);
            endcase
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule